// File: doc/BRIEF.md
# Parallel Camera Frame and Line Framer

This block sits on the pixel clock of an image sensor that drives an 8-bit parallel data bus with vertical and horizontal sync lines. It works out the frame window and the row window from the two sync lines, lets a data byte through only while both windows are open, and sends on one strobed byte per accepted sensor clock. Each accepted byte carries a position tag in the 4:2:2 sequence luma, blue chroma, luma, red chroma. The tag restarts at the first byte of every row.

The block also emits one-cycle pulses for frame start, frame end and line start. It keeps running row and byte counters for the current frame. At the end of a frame it compares the byte count with a configured expected count and raises either a pass pulse or a fail pulse. A frame that is already in progress when reset is released is skipped, because counting begins only at the first start-of-frame edge.

The block runs entirely in the sensor clock domain. Downstream storage or conversion logic consumes the strobed bytes and tags directly.

Top module: `cam_framer`

## Requirements
- R1: While `rst_ni` is low at a clock edge, every output is zero at that edge (synchronous active-low reset).
- R2: The first sample with `vsync_i` low that follows a sample with `vsync_i` high (the falling edge) produces a one-cycle `frame_start_o` on the next cycle. The first high sample after that produces a one-cycle `frame_end_o`, but only for a frame that has started.
- R3: A byte is accepted only at an edge that samples `vsync_i` low and `href_i` high inside a started frame. One cycle later `byte_vld_o` is 1 and `byte_o` equals the sampled `pix_i`. At every other edge `byte_vld_o` is 0.
- R4: After reset, no bytes, line starts or frame pulses appear until the first falling edge of `vsync_i`. Any partial frame seen earlier is dropped.
- R5: Each accepted byte carries `phase_o` following the cycle 0 (luma), 1 (blue chroma), 2 (luma), 3 (red chroma), advancing by one per accepted byte. `is_luma_o` is 1 exactly when `phase_o` is even.
- R6: `line_start_o` is 1 together with the first accepted byte after a low-to-high change of `href_i`, and that byte always carries `phase_o` = 0.
- R7: `row_cnt_o` equals the number of line starts in the current frame, and `byte_cnt_o` equals the number of bytes accepted in it. Both read 0 alongside `frame_start_o`. Both hold their values after the frame ends.
- R8: Together with `frame_end_o`, exactly one of two pulses is 1: `frame_ok_o` when the frame's byte count equals `EXP_BYTES`, otherwise `frame_err_o`.
- R9: Activity on `href_i` while `vsync_i` is high, or between frames, produces no byte, no line start, and no change of either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sensor pixel clock, rising edge active |
| rst_ni | input | 1 | Synchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, high between frames |
| href_i | input | 1 | Row-valid, high while a row is transferred |
| pix_i | input | DATA_W | Parallel pixel data |
| byte_vld_o | output | 1 | Accepted byte strobe |
| byte_o | output | DATA_W | Accepted byte |
| phase_o | output | 2 | 4:2:2 position tag of the byte |
| is_luma_o | output | 1 | Byte is a luma sample |
| line_start_o | output | 1 | First byte of a row |
| frame_start_o | output | 1 | Start-of-frame pulse |
| frame_end_o | output | 1 | End-of-frame pulse |
| frame_ok_o | output | 1 | Frame had the expected byte count |
| frame_err_o | output | 1 | Frame byte count differed |
| row_cnt_o | output | ROW_W | Rows started in the current frame |
| byte_cnt_o | output | CNT_W | Bytes accepted in the current frame |

## Verification
A stuck or misplaced frame-window state shows up on the first byte of a frame. Bytes leak out before the first start edge, or go missing inside the frame, in the very cycle after the offending sample. A wrong tag counter shows on the second byte of a row, or on the first byte of the next row, if the tag does not restart when a row length is not a multiple of four. A counter that drifts stays hidden until frame end, where it flips the pass/fail verdict. So every byte's running count is compared as well, which exposes drift within one cycle.

// File: rtl/cam_framer_pkg.sv
// Shared types for the camera framer.
// Assumes a 4:2:2 byte stream ordered luma, blue chroma, luma, red chroma.
package cam_framer_pkg;
    typedef enum logic [1:0] {
        PH_Y0 = 2'd0,
        PH_CB = 2'd1,
        PH_Y1 = 2'd2,
        PH_CR = 2'd3
    } phase_t;
endpackage

// File: rtl/cam_window.sv
// Frame/row window tracker. Registers the sync lines to find their edges,
// keeps an in-frame flag that opens only on a vsync falling edge, and
// produces same-cycle accept and event strobes. Assumes all inputs are
// already synchronous to the pixel clock.
module cam_window (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vsync_i,
    input  logic href_i,
    output logic accept_o,
    output logic frame_begin_o,
    output logic frame_close_o,
    output logic line_begin_o
);
    logic vs_q, hr_q, in_frame_q;
    logic vs_fall, vs_rise, live;

    // Edge detection and window qualification for the current sample.
    always_comb begin
        vs_fall       = vs_q & ~vsync_i;
        vs_rise       = ~vs_q & vsync_i;
        live          = in_frame_q | vs_fall;
        accept_o      = live & ~vsync_i & href_i;
        line_begin_o  = accept_o & ~hr_q;
        frame_begin_o = vs_fall;
        frame_close_o = vs_rise & in_frame_q;
    end

    // Sync history and frame-open state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vs_q       <= 1'b0;
            hr_q       <= 1'b0;
            in_frame_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            hr_q <= href_i;
            if (vs_fall)      in_frame_q <= 1'b1;
            else if (vs_rise) in_frame_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cam_tagger.sv
// 4:2:2 position tagger. Gives each accepted byte its place in the
// Y/U/Y/V cycle and restarts the cycle at every line start.
module cam_tagger
    import cam_framer_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   accept_i,
    input  logic   line_begin_i,
    output phase_t tag_o
);
    phase_t next_q;

    // Tag of the byte at this edge.
    always_comb tag_o = line_begin_i ? PH_Y0 : next_q;

    // Advance the expected tag on every accepted byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       next_q <= PH_Y0;
        else if (accept_i) next_q <= phase_t'(tag_o + 2'd1);
    end
endmodule

// File: rtl/cam_frame_count.sv
// Per-frame row and byte counters with end-of-frame length verdict.
// Counters clear at frame begin, hold after frame close, and the verdict
// pulses are registered on the same edge as the frame-end pulse.
module cam_frame_count #(
    parameter int ROW_W     = 12,
    parameter int EXP_BYTES = 168960,
    parameter int CNT_W     = $clog2(EXP_BYTES + 1) + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             accept_i,
    input  logic             line_begin_i,
    input  logic             frame_begin_i,
    input  logic             frame_close_i,
    output logic [ROW_W-1:0] row_cnt_o,
    output logic [CNT_W-1:0] byte_cnt_o,
    output logic             ok_o,
    output logic             err_o
);
    localparam logic [CNT_W-1:0] EXP_CNT = CNT_W'(EXP_BYTES);

    // Row and byte counting within the current frame.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            row_cnt_o  <= '0;
            byte_cnt_o <= '0;
        end else if (frame_begin_i) begin
            row_cnt_o  <= ROW_W'(line_begin_i);
            byte_cnt_o <= CNT_W'(accept_i);
        end else begin
            if (line_begin_i) row_cnt_o  <= row_cnt_o + ROW_W'(1);
            if (accept_i)     byte_cnt_o <= byte_cnt_o + CNT_W'(1);
        end
    end

    // Length verdict at frame close.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ok_o  <= 1'b0;
            err_o <= 1'b0;
        end else begin
            ok_o  <= frame_close_i && (byte_cnt_o == EXP_CNT);
            err_o <= frame_close_i && (byte_cnt_o != EXP_CNT);
        end
    end
endmodule

// File: rtl/cam_framer.sv
// Top of the parallel camera framer. Qualifies sensor bytes with the
// vsync/href windows, tags them in 4:2:2 order, counts rows and bytes and
// checks each frame's length. Assumes the sensor clock drives clk_i, so
// no synchronizers are needed. Every output is registered one cycle after
// the sample it describes.
module cam_framer
    import cam_framer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ROW_W     = 12,
    parameter int EXP_BYTES = 168960,
    parameter int CNT_W     = $clog2(EXP_BYTES + 1) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic [DATA_W-1:0] pix_i,
    output logic              byte_vld_o,
    output logic [DATA_W-1:0] byte_o,
    output logic [1:0]        phase_o,
    output logic              is_luma_o,
    output logic              line_start_o,
    output logic              frame_start_o,
    output logic              frame_end_o,
    output logic              frame_ok_o,
    output logic              frame_err_o,
    output logic [ROW_W-1:0]  row_cnt_o,
    output logic [CNT_W-1:0]  byte_cnt_o
);
    logic   accept, frame_begin, frame_close, line_begin;
    phase_t tag;

    cam_window u_window (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .vsync_i       (vsync_i),
        .href_i        (href_i),
        .accept_o      (accept),
        .frame_begin_o (frame_begin),
        .frame_close_o (frame_close),
        .line_begin_o  (line_begin)
    );

    cam_tagger u_tagger (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .accept_i     (accept),
        .line_begin_i (line_begin),
        .tag_o        (tag)
    );

    cam_frame_count #(
        .ROW_W     (ROW_W),
        .EXP_BYTES (EXP_BYTES),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .accept_i      (accept),
        .line_begin_i  (line_begin),
        .frame_begin_i (frame_begin),
        .frame_close_i (frame_close),
        .row_cnt_o     (row_cnt_o),
        .byte_cnt_o    (byte_cnt_o),
        .ok_o          (frame_ok_o),
        .err_o         (frame_err_o)
    );

    // Output stage: byte strobe, data, tag and event pulses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            byte_vld_o    <= 1'b0;
            byte_o        <= '0;
            phase_o       <= 2'd0;
            is_luma_o     <= 1'b0;
            line_start_o  <= 1'b0;
            frame_start_o <= 1'b0;
            frame_end_o   <= 1'b0;
        end else begin
            byte_vld_o    <= accept;
            byte_o        <= accept ? pix_i : '0;
            phase_o       <= accept ? tag : 2'd0;
            is_luma_o     <= accept & ~tag[0];
            line_start_o  <= line_begin;
            frame_start_o <= frame_begin;
            frame_end_o   <= frame_close;
        end
    end

    // Bytes only come from samples with href high and vsync low.
    assert_vld_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_vld_o |-> ($past(href_i) && !$past(vsync_i)));

    // Every line start is a valid luma byte with tag 0.
    assert_line_phase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_start_o |-> (byte_vld_o && phase_o == 2'd0));

    // Byte count steps by one per byte inside a frame.
    assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_vld_o && !frame_start_o) |-> (byte_cnt_o == $past(byte_cnt_o) + CNT_W'(1)));

    // A verdict only appears with the frame-end pulse.
    assert_verdict_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frame_ok_o || frame_err_o) |-> frame_end_o);

    // Start and end of frame never coincide.
    assert_start_end_apart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> !frame_end_o);

    // No bytes while vsync was high.
    assert_vsync_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(vsync_i) |-> !byte_vld_o);
endmodule

// File: tb/cam_framer_test.sv
// Bench: sensor model driving short frames into a small configuration
// (expected length 12 bytes); expected outputs computed from row/byte index.
module cam_framer_test;
    localparam int EXP = 12;
    localparam int CW  = $clog2(EXP + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync = 1'b0, href = 1'b0;
    logic [7:0] pix = '0;
    logic byte_vld, is_luma, line_start, frame_start, frame_end, frame_ok, frame_err;
    logic [7:0] byte_d;
    logic [1:0] phase;
    logic [11:0] row_cnt;
    logic [CW-1:0] byte_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cam_framer #(.DATA_W(8), .ROW_W(12), .EXP_BYTES(EXP)) uut (
        .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .href_i(href), .pix_i(pix),
        .byte_vld_o(byte_vld), .byte_o(byte_d), .phase_o(phase), .is_luma_o(is_luma),
        .line_start_o(line_start), .frame_start_o(frame_start), .frame_end_o(frame_end),
        .frame_ok_o(frame_ok), .frame_err_o(frame_err), .row_cnt_o(row_cnt),
        .byte_cnt_o(byte_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one sample, then look at outputs just after the capturing edge.
    task automatic step(input logic v, input logic h, input logic [7:0] d);
        @(negedge clk);
        vsync = v; href = h; pix = d;
        @(posedge clk);
        #1;
    endtask

    task automatic quiet_checks(input string req, input int keep_cnt);
        check({req, " no byte"}, int'(byte_vld), 0);
        check({req, " no line start"}, int'(line_start), 0);
        check({req, " count held"}, int'(byte_cnt), keep_cnt);
    endtask

    // One complete frame of nl rows by nb bytes, then vsync rises.
    task automatic frame(input int nl, input int nb, input int seed);
        int tot = 0;
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);
        check("R2 frame_start", int'(frame_start), 1);
        check("R7 byte_cnt cleared", int'(byte_cnt), 0);
        check("R7 row_cnt cleared", int'(row_cnt), 0);
        step(1'b0, 1'b0, 8'h00);
        check("R2 start is one cycle", int'(frame_start), 0);
        for (int l = 0; l < nl; l++) begin
            for (int b = 0; b < nb; b++) begin
                logic [7:0] d = 8'((l * 37 + b * 11 + seed) & 255);
                step(1'b0, 1'b1, d);
                tot++;
                check("R3 byte_vld", int'(byte_vld), 1);
                check("R3 byte data", int'(byte_d), int'(d));
                check("R5 phase", int'(phase), b % 4);
                check("R5 is_luma", int'(is_luma), (b % 2 == 0) ? 1 : 0);
                check("R6 line_start", int'(line_start), (b == 0) ? 1 : 0);
                check("R7 row_cnt", int'(row_cnt), l + 1);
                check("R7 byte_cnt", int'(byte_cnt), tot);
            end
            step(1'b0, 1'b0, 8'hA5);
            check("R3 href low no byte", int'(byte_vld), 0);
        end
        step(1'b1, 1'b0, 8'h00);
        check("R2 frame_end", int'(frame_end), 1);
        check("R8 frame_ok", int'(frame_ok), (tot == EXP) ? 1 : 0);
        check("R8 frame_err", int'(frame_err), (tot == EXP) ? 0 : 1);
        step(1'b1, 1'b0, 8'h00);
        check("R2 end is one cycle", int'(frame_end), 0);
        check("R7 count held after end", int'(byte_cnt), tot);
        check("R7 rows held after end", int'(row_cnt), nl);
    endtask

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        check("R1 byte_vld", int'(byte_vld), 0);
        check("R1 frame_start", int'(frame_start), 0);
        check("R1 frame_end", int'(frame_end), 0);
        check("R1 byte_cnt", int'(byte_cnt), 0);
        check("R1 row_cnt", int'(row_cnt), 0);
        check("R1 ok/err", int'(frame_ok | frame_err), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4: partial frame after reset with vsync already low.
        for (int i = 0; i < 10; i++) begin
            step(1'b0, (i % 4) != 0, 8'(i + 1));
            quiet_checks("R4 partial", 0);
            check("R4 no frame_start", int'(frame_start), 0);
        end
        step(1'b1, 1'b0, 8'h00);
        check("R4 no frame_end for dropped frame", int'(frame_end), 0);

        frame(2, 6, 3);   // 12 bytes, expected length
        // R9: href activity during vsync high.
        for (int i = 0; i < 6; i++) begin
            step(1'b1, i[0], 8'hC3);
            quiet_checks("R9 vsync high", EXP);
        end
        frame(3, 5, 17);  // 15 bytes, odd row length, wrong length
        frame(4, 3, 40);  // 12 bytes with three-byte rows
        frame(1, 11, 9);  // one short row

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule